// File: doc/BRIEF.md
# Flow statistics accumulator

This block keeps the running statistics of one traffic flow, one packet at a time. For each packet it takes the packet length, an arrival timestamp, the TCP flag byte and a flag that marks the flow's first packet. It also takes the flow's stored state, which the surrounding pipeline has read from the flow table. One clock edge later it returns the updated state to be written back to the table. In the same cycle it returns a feature vector, cut to the widths that the downstream tree classifier matches on.

The state covers four length statistics: total, minimum, maximum and mean. It covers three inter-arrival statistics (minimum, maximum and mean) and the time elapsed since the flow's first packet. It also holds six saturating flag counters. Before a statistic leaves the block as a feature, it is shifted right and cut to a narrow width. Each feature has its own shift and width, fixed by parameter once the classifier has been trained. Hashing, the table itself and the lookup are outside this block.

Top module: `flow_stats_accum`

## Requirements
- R1: `out_valid` rises exactly one clock after `in_valid` and is low in any cycle that follows a cycle without `in_valid`. After reset, `out_valid`, `st_out` and `feat_out` are all zero.
- R2: When `first_pkt` is set, the incoming state is ignored. The same applies when the incoming count is zero. The new state then has count 1, total, minimum and maximum length equal to the packet length, and start and last timestamps equal to `pkt_ts`. Minimum, maximum and summed inter-arrival times are zero.
- R3: On any other packet, the count grows by one and the total grows by the packet length. The minimum length becomes the smaller of the stored minimum and the packet length, and the maximum length becomes the larger of the stored maximum and the packet length.
- R4: On any other packet, the gap is `pkt_ts` minus the stored last timestamp, taken modulo 2^32. If the stored count is 1, the minimum, maximum and sum of gaps are set to this gap. Otherwise they are updated with it. The last timestamp becomes `pkt_ts` and the start timestamp is kept.
- R5: The duration is `pkt_ts` minus the start timestamp, and it is 0 on a first packet.
- R6: The mean length is the total shifted right by floor(log2(count)). The mean gap is the gap sum shifted right by floor(log2(count-1)), and it is 0 while the count is below 2.
- R7: Counter k counts packets whose flag bit is set, in this order: ACK (bit 4), SYN (bit 1), PSH (bit 3), ECE (bit 6), RST (bit 2), FIN (bit 0). Bits 5 and 7 affect nothing. On a first packet, each counter restarts at 0 or 1.
- R8: The count, the length total, the gap sum and the flag counters hold at their all-ones value instead of wrapping.
- R9: Feature i equals (raw_i >> FEAT_SHIFT[i]) mod 2^FEAT_BITS[i], placed in slot i of `feat_out`, with slot 0 in the low bits. The raw features are:
  - 0: total length
  - 1: minimum length
  - 2: maximum length
  - 3: mean length
  - 4: minimum gap
  - 5: maximum gap
  - 6: mean gap
  - 7: duration
  - 8 to 13: flag counters 0 to 5
- R10: The state vector packs its fields from the most significant end, in this order:
  - count (16 bits)
  - total length (24)
  - minimum length (16)
  - maximum length (16)
  - start timestamp (32)
  - last timestamp (32)
  - minimum gap (32)
  - maximum gap (32)
  - gap sum (32)
  - six 8-bit flag counters, counter 0 lowest

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A packet update is presented |
| pkt_len | input | 16 | Packet length |
| pkt_ts | input | 32 | Arrival timestamp |
| tcp_flags | input | 8 | TCP flag byte |
| first_pkt | input | 1 | Packet opens a new flow entry |
| st_in | input | 280 | Stored flow state read from the table |
| out_valid | output | 1 | Results are valid |
| st_out | output | 280 | Updated flow state to write back |
| feat_out | output | 14*FEAT_W | Scaled feature vector |

## Verification
The assertions check four things on every update:
- the one-cycle valid relation;
- the initial values loaded by a first packet;
- the last timestamp and the length bounds against the packet just presented;
- that the count never wraps and no feature exceeds its configured width.

The exact arithmetic needs the bench's reference scenarios. These cover the power-of-two means at counts that are not powers of two, and the switch from the second-packet rule to the update rule for gaps. They also cover the flag-bit mapping with unused bits set, saturation of every accumulator from a preloaded state, and truncation of features that overflow their width.

// File: rtl/flow_stats_pkg.sv
// Shared widths, state layout and helpers for the flow statistics accumulator.
// Assumes timestamps of a flow are non-decreasing modulo 2^TS_W.
package flow_stats_pkg;

    parameter int LEN_W  = 16;   // packet length width
    parameter int TS_W   = 32;   // timestamp and gap width
    parameter int CNT_W  = 16;   // packet counter width
    parameter int TOT_W  = 24;   // length total width
    parameter int FLAG_W = 8;    // per-flag counter width
    parameter int NFLAG  = 6;    // number of counted flags
    parameter int NFEAT  = 8 + NFLAG;
    parameter int RAW_W  = 32;   // raw feature width before scaling
    parameter int CFG_W  = 5;    // width of one shift / bit-count setting

    // flow entry, most significant field first
    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [TOT_W-1:0]             tot_len;
        logic [LEN_W-1:0]             min_len;
        logic [LEN_W-1:0]             max_len;
        logic [TS_W-1:0]              first_ts;
        logic [TS_W-1:0]              last_ts;
        logic [TS_W-1:0]              min_iat;
        logic [TS_W-1:0]              max_iat;
        logic [TS_W-1:0]              sum_iat;
        logic [NFLAG-1:0][FLAG_W-1:0] flag_cnt;
    } flow_state_t;

    localparam int ST_W = $bits(flow_state_t);

    // bit in the TCP flag byte for each counter: ACK SYN PSH ECE RST FIN
    localparam int FLAG_BIT [NFLAG] = '{4, 1, 3, 6, 2, 0};

    // raw feature slots
    localparam int F_TOT   = 0;
    localparam int F_MINL  = 1;
    localparam int F_MAXL  = 2;
    localparam int F_MEANL = 3;
    localparam int F_MINI  = 4;
    localparam int F_MAXI  = 5;
    localparam int F_MEANI = 6;
    localparam int F_DUR   = 7;
    localparam int F_FLAG0 = 8;

    // index of the highest set bit, 0 for a zero input
    function automatic int flog2(input logic [CNT_W-1:0] v);
        int r;
        r = 0;
        for (int i = 0; i < CNT_W; i++)
            if (v[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/flow_len_stats.sv
// Length statistics: count, total, minimum, maximum and the power-of-two mean.
// Purely combinational; saturates count and total at all ones.
module flow_len_stats
    import flow_stats_pkg::*;
(
    input  logic             first,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [TOT_W-1:0] tot_q,
    input  logic [LEN_W-1:0] min_q,
    input  logic [LEN_W-1:0] max_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic [TOT_W-1:0] tot_d,
    output logic [LEN_W-1:0] min_d,
    output logic [LEN_W-1:0] max_d,
    output logic [RAW_W-1:0] mean_len
);

    logic [CNT_W:0] cnt_sum;
    logic [TOT_W:0] tot_sum;

    // next length fields and mean from the stored fields and this packet
    always_comb begin
        cnt_sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        tot_sum = {1'b0, tot_q} + (TOT_W+1)'(len);
        if (first) begin
            cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
            tot_d = TOT_W'(len);
            min_d = len;
            max_d = len;
        end else begin
            cnt_d = cnt_sum[CNT_W] ? {CNT_W{1'b1}} : cnt_sum[CNT_W-1:0];
            tot_d = tot_sum[TOT_W] ? {TOT_W{1'b1}} : tot_sum[TOT_W-1:0];
            min_d = (len < min_q) ? len : min_q;
            max_d = (len > max_q) ? len : max_q;
        end
        mean_len = RAW_W'(tot_d >> flog2(cnt_d));
    end

endmodule

// File: rtl/flow_iat_stats.sv
// Inter-arrival statistics, timestamps and flow duration.
// Gap values are invalid (held at zero) until a flow has two packets.
module flow_iat_stats
    import flow_stats_pkg::*;
(
    input  logic             first,
    input  logic [TS_W-1:0]  ts,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [TS_W-1:0]  first_ts_q,
    input  logic [TS_W-1:0]  last_ts_q,
    input  logic [TS_W-1:0]  min_q,
    input  logic [TS_W-1:0]  max_q,
    input  logic [TS_W-1:0]  sum_q,
    output logic [TS_W-1:0]  first_ts_d,
    output logic [TS_W-1:0]  last_ts_d,
    output logic [TS_W-1:0]  min_d,
    output logic [TS_W-1:0]  max_d,
    output logic [TS_W-1:0]  sum_d,
    output logic [RAW_W-1:0] mean_iat,
    output logic [RAW_W-1:0] duration
);

    logic [TS_W-1:0] iat;
    logic [TS_W:0]   sum_ext;

    // next gap fields, duration and mean gap
    always_comb begin
        iat       = ts - last_ts_q;
        sum_ext   = {1'b0, sum_q} + {1'b0, iat};
        last_ts_d = ts;
        if (first) begin
            first_ts_d = ts;
            min_d      = '0;
            max_d      = '0;
            sum_d      = '0;
        end else if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
            first_ts_d = first_ts_q;
            min_d      = iat;
            max_d      = iat;
            sum_d      = iat;
        end else begin
            first_ts_d = first_ts_q;
            min_d      = (iat < min_q) ? iat : min_q;
            max_d      = (iat > max_q) ? iat : max_q;
            sum_d      = sum_ext[TS_W] ? {TS_W{1'b1}} : sum_ext[TS_W-1:0];
        end
        duration = RAW_W'(ts - first_ts_d);
        if (cnt_d >= CNT_W'(2))
            mean_iat = RAW_W'(sum_d >> flog2(cnt_d - CNT_W'(1)));
        else
            mean_iat = '0;
    end

endmodule

// File: rtl/flow_flag_ctr.sv
// Saturating per-flag counters, one per entry of FLAG_BIT.
// A first packet restarts every counter at the packet's own flag bit.
module flow_flag_ctr
    import flow_stats_pkg::*;
(
    input  logic                         first,
    input  logic [7:0]                   flags,
    input  logic [NFLAG-1:0][FLAG_W-1:0] cnt_q,
    output logic [NFLAG-1:0][FLAG_W-1:0] cnt_d
);

    logic unused_flags;
    assign unused_flags = ^{flags[7], flags[5]};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        localparam int B = FLAG_BIT[g];
        logic          hit;
        logic [FLAG_W:0] sum;
        assign hit = flags[B];
        assign sum = {1'b0, cnt_q[g]} + (FLAG_W+1)'(hit);
        assign cnt_d[g] = first         ? FLAG_W'(hit) :
                          sum[FLAG_W]   ? {FLAG_W{1'b1}} : sum[FLAG_W-1:0];
    end

endmodule

// File: rtl/flow_feat_scale.sv
// Per-feature right shift and truncation to the classifier key width.
// SHIFT and BITS pack one CW-bit setting per feature, feature 0 lowest.
module flow_feat_scale #(
    parameter int NF = 14,
    parameter int RW = 32,
    parameter int FW = 16,
    parameter int CW = 5,
    parameter logic [NF*CW-1:0] SHIFT = '0,
    parameter logic [NF*CW-1:0] BITS  = '0
) (
    input  logic [NF*RW-1:0] raw,
    output logic [NF*FW-1:0] feat
);

    for (genvar g = 0; g < NF; g++) begin : g_feat
        localparam int SH = int'(SHIFT[g*CW +: CW]);
        localparam int BT = int'(BITS[g*CW +: CW]);
        localparam logic [RW-1:0] MASK = (BT >= RW) ? {RW{1'b1}} :
                                         ((RW'(1) << BT) - RW'(1));
        assign feat[g*FW +: FW] = FW'((raw[g*RW +: RW] >> SH) & MASK);
    end

endmodule

// File: rtl/flow_stats_accum.sv
// Top: one flow-entry update per valid cycle, registered outputs.
// Assumes the caller writes st_out back before the next packet of the flow.
module flow_stats_accum
    import flow_stats_pkg::*;
#(
    parameter int FEAT_W = 16,
    parameter logic [NFEAT*CFG_W-1:0] FEAT_SHIFT =
        {{NFLAG{5'd0}}, {4{5'd4}}, {4{5'd0}}},
    parameter logic [NFEAT*CFG_W-1:0] FEAT_BITS =
        {{NFLAG{5'd8}}, {4{5'd12}}, {4{5'd16}}}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LEN_W-1:0]        pkt_len,
    input  logic [TS_W-1:0]         pkt_ts,
    input  logic [7:0]              tcp_flags,
    input  logic                    first_pkt,
    input  logic [ST_W-1:0]         st_in,
    output logic                    out_valid,
    output logic [ST_W-1:0]         st_out,
    output logic [NFEAT*FEAT_W-1:0] feat_out
);

    localparam int RAW_VEC_W = NFEAT * RAW_W;

    flow_state_t cur;
    flow_state_t nxt;
    logic        first_eff;

    logic [CNT_W-1:0] cnt_d;
    logic [TOT_W-1:0] tot_d;
    logic [LEN_W-1:0] minl_d, maxl_d;
    logic [TS_W-1:0]  fts_d, lts_d, mini_d, maxi_d, sumi_d;
    logic [NFLAG-1:0][FLAG_W-1:0] flg_d;
    logic [RAW_W-1:0] mean_len, mean_iat, duration;
    logic [RAW_VEC_W-1:0]    raw;
    logic [NFEAT*FEAT_W-1:0] feat_d;

    assign cur       = st_in;
    assign first_eff = first_pkt || (cur.cnt == '0);

    flow_len_stats i_len (
        .first    (first_eff),
        .len      (pkt_len),
        .cnt_q    (cur.cnt),
        .tot_q    (cur.tot_len),
        .min_q    (cur.min_len),
        .max_q    (cur.max_len),
        .cnt_d    (cnt_d),
        .tot_d    (tot_d),
        .min_d    (minl_d),
        .max_d    (maxl_d),
        .mean_len (mean_len)
    );

    flow_iat_stats i_iat (
        .first      (first_eff),
        .ts         (pkt_ts),
        .cnt_q      (cur.cnt),
        .cnt_d      (cnt_d),
        .first_ts_q (cur.first_ts),
        .last_ts_q  (cur.last_ts),
        .min_q      (cur.min_iat),
        .max_q      (cur.max_iat),
        .sum_q      (cur.sum_iat),
        .first_ts_d (fts_d),
        .last_ts_d  (lts_d),
        .min_d      (mini_d),
        .max_d      (maxi_d),
        .sum_d      (sumi_d),
        .mean_iat   (mean_iat),
        .duration   (duration)
    );

    flow_flag_ctr i_flag (
        .first (first_eff),
        .flags (tcp_flags),
        .cnt_q (cur.flag_cnt),
        .cnt_d (flg_d)
    );

    assign nxt = '{cnt: cnt_d, tot_len: tot_d, min_len: minl_d, max_len: maxl_d,
                   first_ts: fts_d, last_ts: lts_d, min_iat: mini_d,
                   max_iat: maxi_d, sum_iat: sumi_d, flag_cnt: flg_d};

    // raw feature vector in slot order
    assign raw[F_TOT*RAW_W   +: RAW_W] = RAW_W'(tot_d);
    assign raw[F_MINL*RAW_W  +: RAW_W] = RAW_W'(minl_d);
    assign raw[F_MAXL*RAW_W  +: RAW_W] = RAW_W'(maxl_d);
    assign raw[F_MEANL*RAW_W +: RAW_W] = mean_len;
    assign raw[F_MINI*RAW_W  +: RAW_W] = RAW_W'(mini_d);
    assign raw[F_MAXI*RAW_W  +: RAW_W] = RAW_W'(maxi_d);
    assign raw[F_MEANI*RAW_W +: RAW_W] = mean_iat;
    assign raw[F_DUR*RAW_W   +: RAW_W] = duration;
    for (genvar g = 0; g < NFLAG; g++) begin : g_rawflag
        assign raw[(F_FLAG0+g)*RAW_W +: RAW_W] = RAW_W'(flg_d[g]);
    end

    flow_feat_scale #(
        .NF    (NFEAT),
        .RW    (RAW_W),
        .FW    (FEAT_W),
        .CW    (CFG_W),
        .SHIFT (FEAT_SHIFT),
        .BITS  (FEAT_BITS)
    ) i_scale (
        .raw  (raw),
        .feat (feat_d)
    );

    // output register: state write-back and features, one cycle after input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            st_out    <= '0;
            feat_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                st_out   <= nxt;
                feat_out <= feat_d;
            end
        end
    end

endmodule

// File: rtl/flow_stats_chk.sv
// Checker bound to flow_stats_accum: relates outputs to the previous inputs.
module flow_stats_chk
    import flow_stats_pkg::*;
#(
    parameter int FEAT_W = 16,
    parameter logic [NFEAT*CFG_W-1:0] FEAT_BITS = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LEN_W-1:0]        pkt_len,
    input logic [TS_W-1:0]         pkt_ts,
    input logic                    first_pkt,
    input logic [ST_W-1:0]         st_in,
    input logic                    out_valid,
    input logic [ST_W-1:0]         st_out,
    input logic [NFEAT*FEAT_W-1:0] feat_out
);

    flow_state_t si, so;
    logic unused_chk;
    assign si = st_in;
    assign so = st_out;
    assign unused_chk = ^{st_in, st_out, feat_out};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_FIRST_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && first_pkt |=> so.cnt == CNT_W'(1) && so.min_len == $past(pkt_len)
        && so.max_len == $past(pkt_len) && so.first_ts == $past(pkt_ts)); // R2
    AST_FIRST_GAPS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && first_pkt |=> so.min_iat == '0 && so.max_iat == '0
        && so.sum_iat == '0); // R2
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> so.min_len <= $past(pkt_len) && so.max_len >= $past(pkt_len)); // R3
    AST_LAST_TS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> so.last_ts == $past(pkt_ts)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !first_pkt && si.cnt != '0 |=> so.cnt >= $past(si.cnt)
        && so.cnt != '0); // R8

    for (genvar g = 0; g < NFEAT; g++) begin : g_fit
        localparam int BT = int'(FEAT_BITS[g*CFG_W +: CFG_W]);
        if (BT < FEAT_W) begin : g_narrow
            AST_FEAT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> feat_out[g*FEAT_W +: FEAT_W] < FEAT_W'(1 << BT)); // R9
        end
    end

endmodule

bind flow_stats_accum flow_stats_chk #(
    .FEAT_W    (FEAT_W),
    .FEAT_BITS (FEAT_BITS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pkt_len   (pkt_len),
    .pkt_ts    (pkt_ts),
    .first_pkt (first_pkt),
    .st_in     (st_in),
    .out_valid (out_valid),
    .st_out    (st_out),
    .feat_out  (feat_out)
);

// File: tb/test_flow_stats_accum.sv
`timescale 1ns/1ps
module test_flow_stats_accum;
    import flow_stats_pkg::*;

    localparam int FW = 16;
    localparam int NF = 14;
    localparam logic [NF*5-1:0] P_SHIFT = {{6{5'd0}}, {4{5'd3}}, {3{5'd0}}, 5'd1};
    localparam logic [NF*5-1:0] P_BITS  = {{6{5'd4}}, {4{5'd10}}, {4{5'd16}}};
    localparam int TB_SHIFT [NF] = '{1,0,0,0,3,3,3,3,0,0,0,0,0,0};
    localparam int TB_BITS  [NF] = '{16,16,16,16,10,10,10,10,4,4,4,4,4,4};
    localparam int FBIT [6] = '{4,1,3,6,2,0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic [31:0] pkt_ts = '0;
    logic [7:0]  tcp_flags = '0;
    logic first_pkt = 1'b0;
    logic [ST_W-1:0] st_in = '0;
    logic out_valid;
    logic [ST_W-1:0] st_out;
    logic [NF*FW-1:0] feat_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        flow_state_t      st;
        logic [NF*FW-1:0] feat;
        string            tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    flow_stats_accum #(.FEAT_W(FW), .FEAT_SHIFT(P_SHIFT), .FEAT_BITS(P_BITS)) i_flow_stats_accum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_len(pkt_len),
        .pkt_ts(pkt_ts), .tcp_flags(tcp_flags), .first_pkt(first_pkt),
        .st_in(st_in), .out_valid(out_valid), .st_out(st_out), .feat_out(feat_out)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lg(input longint v);
        int r = 0;
        while (v > 1) begin v = v >> 1; r++; end
        return r;
    endfunction

    // reference update from the requirements (R2, R3, R4, R7, R8)
    function automatic flow_state_t model(input flow_state_t s, input longint len,
                                          input logic [31:0] ts, input logic [7:0] fl, input bit first);
        flow_state_t n;
        logic [31:0] gap;
        bit f;
        f = first || (s.cnt == 0);
        gap = ts - s.last_ts;
        n.last_ts = ts;
        if (f) begin
            n.cnt = 1; n.tot_len = 24'(len); n.min_len = 16'(len); n.max_len = 16'(len);
            n.first_ts = ts; n.min_iat = 0; n.max_iat = 0; n.sum_iat = 0;
        end else begin
            n.cnt = (longint'(s.cnt) + 1 > 65535) ? 16'hFFFF : s.cnt + 16'd1;
            n.tot_len = (longint'(s.tot_len) + len > 24'hFFFFFF) ? 24'hFFFFFF : 24'(longint'(s.tot_len) + len);
            n.min_len = (len < s.min_len) ? 16'(len) : s.min_len;
            n.max_len = (len > s.max_len) ? 16'(len) : s.max_len;
            n.first_ts = s.first_ts;
            if (s.cnt == 1) begin
                n.min_iat = gap; n.max_iat = gap; n.sum_iat = gap;
            end else begin
                n.min_iat = (gap < s.min_iat) ? gap : s.min_iat;
                n.max_iat = (gap > s.max_iat) ? gap : s.max_iat;
                n.sum_iat = (longint'(s.sum_iat) + gap > 64'hFFFFFFFF) ? 32'hFFFFFFFF : s.sum_iat + gap;
            end
        end
        for (int k = 0; k < 6; k++) begin
            if (f) n.flag_cnt[k] = {7'd0, fl[FBIT[k]]};
            else if (s.flag_cnt[k] == 8'hFF) n.flag_cnt[k] = 8'hFF;
            else n.flag_cnt[k] = s.flag_cnt[k] + {7'd0, fl[FBIT[k]]};
        end
        return n;
    endfunction

    // reference features (R5, R6, R9)
    function automatic logic [NF*FW-1:0] feats(input flow_state_t n, input logic [31:0] ts);
        longint raw [NF];
        logic [NF*FW-1:0] v;
        logic [31:0] dur;
        dur = ts - n.first_ts;
        raw[0] = n.tot_len; raw[1] = n.min_len; raw[2] = n.max_len;
        raw[3] = longint'(n.tot_len) >> lg(n.cnt);
        raw[4] = n.min_iat; raw[5] = n.max_iat;
        raw[6] = (n.cnt >= 2) ? (longint'(n.sum_iat) >> lg(longint'(n.cnt) - 1)) : 0;
        raw[7] = dur;
        for (int k = 0; k < 6; k++) raw[8+k] = n.flag_cnt[k];
        for (int i = 0; i < NF; i++)
            v[i*FW +: FW] = 16'((raw[i] >> TB_SHIFT[i]) & ((64'd1 << TB_BITS[i]) - 1));
        return v;
    endfunction

    // driver: present one packet, push the expected result, advance a cycle
    task automatic send(input flow_state_t s, input int len, input logic [31:0] ts,
                        input logic [7:0] fl, input bit first, input string tag,
                        output flow_state_t n);
        exp_t e;
        n = model(s, len, ts, fl, first);
        e.st = n; e.feat = feats(n, ts); e.tag = tag;
        q.push_back(e);
        in_valid = 1'b1; pkt_len = 16'(len); pkt_ts = ts; tcp_flags = fl;
        first_pkt = first; st_in = s;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; first_pkt = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare each result
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (q.size() == 0) begin
                chk("R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                flow_state_t a;
                e = q.pop_front();
                a = st_out;
                chk({e.tag, " R10"}, "state vector", st_out, e.st);
                chk({e.tag, " R3"}, "count", a.cnt, e.st.cnt);
                chk({e.tag, " R3"}, "total", a.tot_len, e.st.tot_len);
                chk({e.tag, " R3"}, "min/max len", {a.min_len, a.max_len}, {e.st.min_len, e.st.max_len});
                chk({e.tag, " R4"}, "timestamps", {a.first_ts, a.last_ts}, {e.st.first_ts, e.st.last_ts});
                chk({e.tag, " R4"}, "min/max gap", {a.min_iat, a.max_iat}, {e.st.min_iat, e.st.max_iat});
                chk({e.tag, " R4"}, "gap sum", a.sum_iat, e.st.sum_iat);
                chk({e.tag, " R7"}, "flag counters", a.flag_cnt, e.st.flag_cnt);
                for (int i = 0; i < NF; i++)
                    chk({e.tag, (i == 3 || i == 6) ? " R6" : (i == 7) ? " R5" : " R9"},
                        $sformatf("feature %0d", i), feat_out[i*FW +: FW], e.feat[i*FW +: FW]);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        flow_state_t a, b, s, junk;
        repeat (3) @(negedge clk);
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset st_out", st_out, 0);
        chk("R1", "reset feat_out", feat_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: first packet with a garbage stored entry
        junk = '1;
        send(junk, 100, 32'd1000, 8'h02, 1, "R2 first", a);
        send(a, 60, 32'd1100, 8'h10, 0, "second", a);
        send(a, 1500, 32'd1150, 8'h18, 0, "third", a);
        // R7: URG and CWR set alongside FIN and ACK
        send(a, 40, 32'd1400, 8'hB1, 0, "R7 unused bits", a);
        idle(1);
        chk("R1", "idle out_valid low", out_valid, 0);
        send(a, 800, 32'd1420, 8'h44, 0, "fifth", a);

        // interleaved second flow, lengths and gaps vary (R6 non power-of-two counts)
        send(junk, 64, 32'hFFFF_FF00, 8'h02, 1, "R2 flow b", b);
        for (int k = 1; k < 20; k++) begin
            send(b, 64 + (k * 37) % 900, b.last_ts + 32'(10 + (k * 13) % 50),
                 8'(k * 29), 0, "R6 flow b", b);
            if (k == 9) send(a, 90, a.last_ts + 32'd7, 8'h01, 0, "flow a", a);
        end

        // R8: saturation from a preloaded entry
        s = '0;
        s.cnt = 16'hFFFF; s.tot_len = 24'hFFFF00; s.min_len = 10; s.max_len = 2000;
        s.first_ts = 0; s.last_ts = 5000; s.min_iat = 5; s.max_iat = 900;
        s.sum_iat = 32'hFFFF_FF00;
        for (int k = 0; k < 6; k++) s.flag_cnt[k] = 8'hFF;
        send(s, 1000, 32'd6000, 8'hFF, 0, "R8 saturate", s);
        send(s, 3, 32'd6001, 8'h5F, 0, "R8 hold", s);

        // count zero without first_pkt is treated as new (R2)
        junk.cnt = '0;
        send(junk, 300, 32'd77, 8'h04, 0, "R2 zero count", a);

        idle(3);
        chk("R1", "all results seen", q.size(), 0);
        chk("R1", "out_valid low after idle", out_valid, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule